// File: doc/BRIEF.md
# Write-Allocate Second-Level Cache Access Controller

This block decides the fate of each request that reaches one shared second-level cache slice. It compares the incoming block address against a two-way tag array, looks it up in a small table of outstanding misses, and weighs the request against the free space in a bounded queue toward the memory controller. It answers HIT, MISS or FAIL one cycle later. In the same cycle it updates line state and pushes any lower-level requests the access needs. Write hits are absorbed as dirty lines. Write misses are forwarded and, when allocation is enabled, also fetch the full line, which may push out a dirty victim.

Because a write miss with allocation can emit three requests at once, the controller admits it only when the queue has room for all three and the miss table can track the fetch. A request that cannot be taken completely is refused with FAIL, and nothing changes. The requester retries later. Fills returning from memory release their miss-table entry and make the line usable. The queue is drained by a ready signal at its head.

Top module: `l2_wa_ctrl`

## Requirements
- R1: After reset no response is valid, the miss queue is empty and every line is invalid, so the first read of any block misses.
- R2: With write policy code 8'h42 ('B', write-back), a write that hits a ready line answers HIT (status 0), marks the line dirty, makes it most recently used and pushes nothing into the queue.
- R3: With allocate code 8'h57 ('W'), a write miss is admitted only if the queue holds at most QDEPTH-3 entries and one of two things is true: the block is already in the miss table with fewer than MAXMERGE merged accesses, or it is absent from the table, a table entry is free and the set has a replaceable way. Otherwise the write miss answers FAIL (status 2) and changes nothing.
- R4: An admitted allocating write miss answers MISS (status 1). It pushes the write (kind 0) first and, unless it merges into an existing table entry, then a full-line read of the block (kind 1), then a writeback (kind 2) of a dirty victim. Only the write event is raised for it.
- R5: With any allocate code other than 'W', a write miss needs one free queue slot. It pushes only the write, raises the write event and answers MISS, or answers FAIL when the queue is full.
- R6: A read miss needs at most QDEPTH-2 queue entries. A new fetch pushes a read and raises the read event. A dirty victim adds a writeback after the read and raises the writeback event.
- R7: A read hit answers HIT and makes the line most recently used. An atomic read hit also marks the line dirty, so its later eviction produces a writeback.
- R8: An access to a block that is being fetched merges into the block's table entry without a new read, up to MAXMERGE accesses per entry. Beyond that limit the access fails.
- R9: A fill for a tracked block frees its table entry and makes the line a ready clean line. A request in the same cycle already sees the fill's effect. A fill for an untracked block has no effect.
- R10: With write policy code 8'h54 ('T', write-through), a write hit pushes one write and answers HIT, without dirtying the line. When the queue is full it answers FAIL.
- R11: A write under any other write policy code, including 'R' (read-only) and 'E' (write-evict), answers FAIL with cfg_err high and changes nothing. Reads are served normally under those codes.
- R12: The victim way is chosen in this order: an invalid way, then the least recently used way if it is not being fetched, then the other way if it is not being fetched. When both ways are being fetched for other blocks, a new miss fails.
- R13: The queue delivers entries in push order. The head is presented on mq_kind and mq_blk while mq_valid is high, and it is removed on a clock edge where mq_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wpol | input | 8 | Write policy code (ASCII character) |
| cfg_walloc | input | 8 | Write allocate code (ASCII character) |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | Request is a write |
| req_atomic | input | 1 | Read request is atomic |
| req_blk | input | BLKW | Block address of the request |
| fill_valid | input | 1 | A line fill returns this cycle |
| fill_blk | input | BLKW | Block address of the fill |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_status | output | 2 | 0 HIT, 1 MISS, 2 FAIL |
| rsp_wr_ev | output | 1 | A write was sent for this request |
| rsp_rd_ev | output | 1 | A fetch read was sent and reported |
| rsp_wb_ev | output | 1 | A victim writeback was sent and reported |
| cfg_err | output | 1 | Write refused because of an illegal policy code |
| mq_valid | output | 1 | Miss queue holds at least one entry |
| mq_kind | output | 2 | Head entry kind: 0 write, 1 read, 2 writeback |
| mq_blk | output | BLKW | Head entry block address |
| mq_ready | input | 1 | Memory side takes the head entry |

## Verification
Directed sequences cover each access path: read miss and fill, write hit under write-back, atomic hits that dirty a line which a later eviction then writes back, merging up to and past the limit, and allocating write misses both into a fresh entry and onto a block already being fetched. A back-pressured queue separates the three-slot admission rule for allocating writes from the two-slot rule for reads and the one-slot rule for plain writes. A set with both ways in flight shows that the victim rule refuses the access rather than evicting a line being fetched. A long random phase then mixes policy codes, fills, reused block addresses and stalls, so that the event flags and the order of queue entries are compared against the reference model across many combinations of state.

// File: rtl/l2_wa_ctrl.sv
module l2_wa_ctrl #(
  parameter int BLKW     = 16,
  parameter int NSETS    = 16,
  parameter int NMSHR    = 4,
  parameter int MAXMERGE = 4,
  parameter int QDEPTH   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cfg_wpol,
  input  logic [7:0]      cfg_walloc,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_atomic,
  input  logic [BLKW-1:0] req_blk,
  input  logic            fill_valid,
  input  logic [BLKW-1:0] fill_blk,
  output logic            rsp_valid,
  output logic [1:0]      rsp_status,
  output logic            rsp_wr_ev,
  output logic            rsp_rd_ev,
  output logic            rsp_wb_ev,
  output logic            cfg_err,
  output logic            mq_valid,
  output logic [1:0]      mq_kind,
  output logic [BLKW-1:0] mq_blk,
  input  logic            mq_ready
);
  localparam int SETW = $clog2(NSETS);
  localparam int TAGW = BLKW - SETW;
  localparam int QW   = $clog2(QDEPTH);
  localparam int CW   = $clog2(QDEPTH + 1);
  localparam int MW   = $clog2(MAXMERGE + 1);
  localparam int MIW  = (NMSHR > 1) ? $clog2(NMSHR) : 1;
  localparam logic [1:0] ST_HIT = 2'd0, ST_MISS = 2'd1, ST_FAIL = 2'd2;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WB = 2'd2;

  logic [TAGW-1:0] tag_q [NSETS][2];
  logic            vld_q [NSETS][2];
  logic            drt_q [NSETS][2];
  logic            pnd_q [NSETS][2];
  logic            lru_q [NSETS];
  logic            mv_q  [NMSHR];
  logic [BLKW-1:0] mb_q  [NMSHR];
  logic [MW-1:0]   mc_q  [NMSHR];
  logic [1:0]      qk_q  [QDEPTH];
  logic [BLKW-1:0] qb_q  [QDEPTH];
  logic [QW-1:0]   head_q;
  logic [CW-1:0]   cnt_q;

  logic [SETW-1:0] rset, fset;
  logic [TAGW-1:0] rtag, ftag;
  assign rset = req_blk[SETW-1:0];
  assign rtag = req_blk[BLKW-1:SETW];
  assign fset = fill_blk[SETW-1:0];
  assign ftag = fill_blk[BLKW-1:SETW];

  logic [NMSHR-1:0] fhit, mlive, mh;
  logic fill_any;
  always_comb
    for (int i = 0; i < NMSHR; i++) begin
      fhit[i]  = fill_valid && mv_q[i] && (mb_q[i] == fill_blk);
      mlive[i] = mv_q[i] && !fhit[i];
      mh[i]    = mlive[i] && (mb_q[i] == req_blk);
    end
  assign fill_any = |fhit;

  logic [1:0] pe, hitv;
  always_comb
    for (int w = 0; w < 2; w++) begin
      pe[w]   = pnd_q[rset][w] && !(fill_any && fset == rset && tag_q[rset][w] == ftag);
      hitv[w] = vld_q[rset][w] && tag_q[rset][w] == rtag && !pe[w];
    end
  logic is_hit, hway;
  assign is_hit = |hitv;
  assign hway   = hitv[1];

  logic [MW-1:0]  mcnt;
  logic [MIW-1:0] midx, fidx;
  logic ffree, mhit, room;
  always_comb begin
    mcnt = '0; midx = '0; fidx = '0; ffree = 1'b0;
    for (int i = 0; i < NMSHR; i++) begin
      if (mh[i]) begin mcnt = mc_q[i]; midx = MIW'(i); end
      if (!mlive[i] && !ffree) begin ffree = 1'b1; fidx = MIW'(i); end
    end
  end
  assign mhit = |mh;
  assign room = mcnt < MW'(MAXMERGE);

  logic vw, vok, lw, vdirty, mshr_ok;
  logic [BLKW-1:0] vblk;
  always_comb begin
    lw = lru_q[rset]; vok = 1'b1; vw = 1'b0;
    if (!vld_q[rset][0])      vw = 1'b0;
    else if (!vld_q[rset][1]) vw = 1'b1;
    else if (!pe[lw])         vw = lw;
    else if (!pe[~lw])        vw = ~lw;
    else                      vok = 1'b0;
  end
  assign vdirty  = vld_q[rset][vw] && drt_q[rset][vw];
  assign vblk    = {tag_q[rset][vw], rset};
  assign mshr_ok = mhit ? room : (ffree && vok);

  logic wp_b, wp_t, walloc;
  assign wp_b   = cfg_wpol == 8'h42;
  assign wp_t   = cfg_wpol == 8'h54;
  assign walloc = cfg_walloc == 8'h57;

  logic [1:0]      st, pk [3];
  logic [BLKW-1:0] pb [3];
  logic [1:0]      npush;
  logic ev_wr, ev_rd, ev_wb, err, upd_lru, set_dirty, merge, alloc;
  always_comb begin
    st = ST_HIT; ev_wr = 0; ev_rd = 0; ev_wb = 0; err = 0;
    upd_lru = 0; set_dirty = 0; merge = 0; alloc = 0; npush = 2'd0;
    for (int k = 0; k < 3; k++) begin pk[k] = K_WR; pb[k] = req_blk; end
    if (req_valid) begin
      if (req_write) begin
        if (!(wp_b || wp_t)) begin
          st = ST_FAIL; err = 1'b1;
        end else if (is_hit) begin
          if (wp_b) begin
            upd_lru = 1'b1; set_dirty = 1'b1;
          end else if (int'(cnt_q) < QDEPTH) begin
            upd_lru = 1'b1; npush = 2'd1; ev_wr = 1'b1;
          end else st = ST_FAIL;
        end else if (walloc) begin
          if (int'(cnt_q) + 3 <= QDEPTH && mshr_ok) begin
            st = ST_MISS; ev_wr = 1'b1; npush = 2'd1;
            if (mhit) merge = 1'b1;
            else begin
              alloc = 1'b1; pk[1] = K_RD; npush = 2'd2;
              if (vdirty) begin pk[2] = K_WB; pb[2] = vblk; npush = 2'd3; end
            end
          end else st = ST_FAIL;
        end else if (int'(cnt_q) < QDEPTH) begin
          st = ST_MISS; ev_wr = 1'b1; npush = 2'd1;
        end else st = ST_FAIL;
      end else begin
        if (is_hit) begin
          upd_lru = 1'b1; set_dirty = req_atomic;
        end else if (int'(cnt_q) + 2 <= QDEPTH && mshr_ok) begin
          st = ST_MISS;
          if (mhit) merge = 1'b1;
          else begin
            alloc = 1'b1; ev_rd = 1'b1; pk[0] = K_RD; npush = 2'd1;
            if (vdirty) begin pk[1] = K_WB; pb[1] = vblk; npush = 2'd2; ev_wb = 1'b1; end
          end
        end else st = ST_FAIL;
      end
    end
  end

  logic          pop;
  logic [QW-1:0] tail;
  assign mq_valid = cnt_q != '0;
  assign mq_kind  = qk_q[head_q];
  assign mq_blk   = qb_q[head_q];
  assign pop      = mq_valid && mq_ready;
  assign tail     = head_q + QW'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_status <= ST_HIT; rsp_wr_ev <= 1'b0;
      rsp_rd_ev <= 1'b0; rsp_wb_ev <= 1'b0; cfg_err <= 1'b0;
      head_q <= '0; cnt_q <= '0;
      for (int s = 0; s < NSETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          tag_q[s][w] <= '0; vld_q[s][w] <= 1'b0; drt_q[s][w] <= 1'b0; pnd_q[s][w] <= 1'b0;
        end
      end
      for (int i = 0; i < NMSHR; i++) begin mv_q[i] <= 1'b0; mb_q[i] <= '0; mc_q[i] <= '0; end
      for (int k = 0; k < QDEPTH; k++) begin qk_q[k] <= K_WR; qb_q[k] <= '0; end
    end else begin
      rsp_valid <= req_valid; rsp_status <= st; rsp_wr_ev <= ev_wr;
      rsp_rd_ev <= ev_rd; rsp_wb_ev <= ev_wb; cfg_err <= err;
      for (int i = 0; i < NMSHR; i++) if (fhit[i]) mv_q[i] <= 1'b0;
      for (int w = 0; w < 2; w++)
        if (fill_any && pnd_q[fset][w] && tag_q[fset][w] == ftag) pnd_q[fset][w] <= 1'b0;
      if (upd_lru) lru_q[rset] <= ~hway;
      if (set_dirty) drt_q[rset][hway] <= 1'b1;
      if (merge) mc_q[midx] <= mcnt + MW'(1);
      if (alloc) begin
        mv_q[fidx] <= 1'b1; mb_q[fidx] <= req_blk; mc_q[fidx] <= MW'(1);
        tag_q[rset][vw] <= rtag; vld_q[rset][vw] <= 1'b1;
        drt_q[rset][vw] <= 1'b0; pnd_q[rset][vw] <= 1'b1;
        lru_q[rset] <= ~vw;
      end
      for (int k = 0; k < 3; k++)
        if (k < int'(npush)) begin
          qk_q[tail + QW'(k)] <= pk[k];
          qb_q[tail + QW'(k)] <= pb[k];
        end
      head_q <= head_q + QW'(pop);
      cnt_q  <= cnt_q + CW'(npush) - CW'(pop);
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(QDEPTH)); // R3
  AST_FAIL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_FAIL) |-> cnt_q <= $past(cnt_q)); // R3
  AST_WB_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_HIT && $past(req_write && cfg_wpol == 8'h42))
      |-> cnt_q <= $past(cnt_q)); // R2
  AST_NO_ALLOC_READ_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_ev |-> !$past(req_write)); // R4
  AST_WRITE_EVENT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_ev |-> $past(req_write)); // R5
  AST_ERR_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (rsp_status == ST_FAIL && $past(req_write))); // R11
endmodule

// File: tb/l2_wa_ctrl_bench.sv
module l2_wa_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int BLKW = 8, NSETS = 4, NMSHR = 3, MAXMERGE = 2, QDEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_wpol = 8'h42, cfg_walloc = 8'h57;
  logic req_valid = 0, req_write = 0, req_atomic = 0, fill_valid = 0, mq_ready = 1;
  logic [BLKW-1:0] req_blk = '0, fill_blk = '0;
  logic rsp_valid, rsp_wr_ev, rsp_rd_ev, rsp_wb_ev, cfg_err, mq_valid;
  logic [1:0] rsp_status, mq_kind;
  logic [BLKW-1:0] mq_blk;

  l2_wa_ctrl #(.BLKW(BLKW), .NSETS(NSETS), .NMSHR(NMSHR), .MAXMERGE(MAXMERGE), .QDEPTH(QDEPTH)) u_l2_wa_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wpol(cfg_wpol), .cfg_walloc(cfg_walloc),
    .req_valid(req_valid), .req_write(req_write), .req_atomic(req_atomic), .req_blk(req_blk),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_wr_ev(rsp_wr_ev), .rsp_rd_ev(rsp_rd_ev), .rsp_wb_ev(rsp_wb_ev), .cfg_err(cfg_err),
    .mq_valid(mq_valid), .mq_kind(mq_kind), .mq_blk(mq_blk), .mq_ready(mq_ready));

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model
  int  mtag [NSETS][2];
  bit  mval [NSETS][2], mdrt [NSETS][2], mpnd [NSETS][2];
  bit  mlru [NSETS];
  bit  hv [NMSHR];
  int  hb [NMSHR], hc [NMSHR];
  int  qk [$], qb [$];
  bit  e_valid, e_wr, e_rd, e_wb, e_err;
  int  e_st;
  string e_tag = "R1";

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) begin mtag[s][w] = 0; mval[s][w] = 0; mdrt[s][w] = 0; mpnd[s][w] = 0; end
    end
    for (int i = 0; i < NMSHR; i++) hv[i] = 0;
    qk.delete(); qb.delete();
    e_valid = 0;
  endtask

  task automatic model_step();
    int s, t, hw, mj, fj, vw, n0, b;
    bit fany, mok, walloc;
    if (fill_valid) begin
      fany = 0;
      for (int i = 0; i < NMSHR; i++) if (hv[i] && hb[i] == int'(fill_blk)) begin hv[i] = 0; fany = 1; end
      if (fany)
        for (int w = 0; w < 2; w++)
          if (mpnd[fill_blk % NSETS][w] && mtag[fill_blk % NSETS][w] == fill_blk / NSETS)
            mpnd[fill_blk % NSETS][w] = 0;
    end
    n0 = qk.size();
    if (n0 > 0 && mq_ready) begin void'(qk.pop_front()); void'(qb.pop_front()); end
    e_valid = req_valid; e_st = 0; e_wr = 0; e_rd = 0; e_wb = 0; e_err = 0;
    if (!req_valid) return;
    b = int'(req_blk); s = b % NSETS; t = b / NSETS;
    hw = -1; mj = -1; fj = -1; vw = -1;
    for (int w = 0; w < 2; w++) if (mval[s][w] && !mpnd[s][w] && mtag[s][w] == t) hw = w;
    for (int i = 0; i < NMSHR; i++) begin
      if (hv[i] && hb[i] == b) mj = i;
      if (!hv[i] && fj < 0) fj = i;
    end
    if (!mval[s][0]) vw = 0;
    else if (!mval[s][1]) vw = 1;
    else if (!mpnd[s][mlru[s]]) vw = mlru[s];
    else if (!mpnd[s][!mlru[s]]) vw = !mlru[s];
    mok = (mj >= 0) ? (hc[mj] < MAXMERGE) : (fj >= 0 && vw >= 0);
    walloc = cfg_walloc == 8'h57;
    if (req_write) begin
      if (cfg_wpol != 8'h42 && cfg_wpol != 8'h54) begin e_st = 2; e_err = 1; e_tag = "R11"; end
      else if (hw >= 0) begin
        if (cfg_wpol == 8'h42) begin mdrt[s][hw] = 1; mlru[s] = (hw == 0); e_tag = "R2"; end
        else if (n0 < QDEPTH) begin mlru[s] = (hw == 0); qk.push_back(0); qb.push_back(b); e_wr = 1; e_tag = "R10"; end
        else begin e_st = 2; e_tag = "R10"; end
      end else if (walloc) begin
        if (n0 + 3 <= QDEPTH && mok) begin
          e_st = 1; e_wr = 1; qk.push_back(0); qb.push_back(b);
          if (mj >= 0) begin hc[mj]++; e_tag = "R8"; end
          else begin
            e_tag = "R4";
            qk.push_back(1); qb.push_back(b);
            if (mval[s][vw] && mdrt[s][vw]) begin qk.push_back(2); qb.push_back(mtag[s][vw] * NSETS + s); end
            hv[fj] = 1; hb[fj] = b; hc[fj] = 1;
            mtag[s][vw] = t; mval[s][vw] = 1; mdrt[s][vw] = 0; mpnd[s][vw] = 1; mlru[s] = (vw == 0);
          end
        end else begin e_st = 2; e_tag = (mj >= 0 && n0 + 3 <= QDEPTH) ? "R8" : (vw < 0 ? "R12" : "R3"); end
      end else if (n0 < QDEPTH) begin e_st = 1; e_wr = 1; qk.push_back(0); qb.push_back(b); e_tag = "R5"; end
      else begin e_st = 2; e_tag = "R5"; end
    end else begin
      if (hw >= 0) begin
        mlru[s] = (hw == 0);
        if (req_atomic) begin mdrt[s][hw] = 1; e_tag = "R7"; end else e_tag = "R9";
      end else if (n0 + 2 <= QDEPTH && mok) begin
        e_st = 1;
        if (mj >= 0) begin hc[mj]++; e_tag = "R8"; end
        else begin
          e_tag = "R6"; e_rd = 1; qk.push_back(1); qb.push_back(b);
          if (mval[s][vw] && mdrt[s][vw]) begin
            qk.push_back(2); qb.push_back(mtag[s][vw] * NSETS + s); e_wb = 1;
          end
          hv[fj] = 1; hb[fj] = b; hc[fj] = 1;
          mtag[s][vw] = t; mval[s][vw] = 1; mdrt[s][vw] = 0; mpnd[s][vw] = 1; mlru[s] = (vw == 0);
        end
      end else begin e_st = 2; e_tag = (mj >= 0 && n0 + 2 <= QDEPTH) ? "R8" : (vw < 0 && mj < 0 && fj >= 0 ? "R12" : "R6"); end
    end
  endtask

  always @(posedge clk) if (!rst_n) model_reset(); else model_step();

  always @(negedge clk) if (rst_n && !done) begin
    logic [5:0] act, exp_v;
    act   = {rsp_status, rsp_wr_ev, rsp_rd_ev, rsp_wb_ev, cfg_err};
    exp_v = {e_st[1:0], e_wr, e_rd, e_wb, e_err};
    vectors++;
    if (rsp_valid !== e_valid || (e_valid && act !== exp_v)) begin
      miscompares++;
      $display("FAIL %s response: actual valid=%0b bits=%b expected valid=%0b bits=%b", e_tag, rsp_valid, act, e_valid, exp_v);
    end
    vectors++;
    if (mq_valid !== (qk.size() > 0) || (mq_valid && (int'(mq_kind) != qk[0] || int'(mq_blk) != qb[0]))) begin
      miscompares++;
      $display("FAIL R13 queue head: actual v=%0b k=%0d b=%0d expected v=%0b k=%0d b=%0d",
               mq_valid, mq_kind, mq_blk, qk.size() > 0, (qk.size() > 0) ? qk[0] : -1, (qk.size() > 0) ? qb[0] : -1);
    end
  end

  task automatic rq(input bit w, input bit a, input int b);
    req_valid = 1; req_write = w; req_atomic = a; req_blk = BLKW'(b);
    @(negedge clk);
    req_valid = 0; req_atomic = 0;
  endtask
  task automatic fl(input int b);
    fill_valid = 1; fill_blk = BLKW'(b);
    @(negedge clk);
    fill_valid = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL R13 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || mq_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset state: actual rsp=%0b mq=%0b expected 0 0", rsp_valid, mq_valid);
    end
    // read miss, fill, write-back hit, dirty victim (R1 R6 R9 R2)
    rq(0, 0, 1); idle(1); fl(1); rq(1, 0, 1);
    rq(0, 0, 5); fl(5); rq(0, 0, 9); idle(2); fl(9);
    // atomic hit dirties, later eviction writes back (R7)
    rq(0, 1, 5); rq(0, 0, 13); fl(13); rq(0, 0, 1); fl(1);
    // merging up to and past the limit (R8)
    rq(0, 0, 2); rq(0, 0, 2); rq(1, 0, 2); fl(2); rq(0, 0, 2);
    // allocating write misses (R4), with dirty victim
    rq(1, 0, 6); fl(6); rq(1, 0, 2); rq(1, 0, 6); rq(1, 0, 10); rq(1, 0, 14); idle(4); fl(10); fl(14);
    // back-pressure: admission limits (R3 R5 R6)
    mq_ready = 0;
    rq(0, 0, 3); rq(1, 0, 7); rq(1, 0, 11); rq(0, 0, 15);
    cfg_walloc = 8'h4E; rq(1, 0, 20); rq(1, 0, 21);
    mq_ready = 1; idle(6); fl(3); fl(7); fl(15);
    rq(1, 0, 28); idle(2);
    // write-through hit (R10)
    cfg_walloc = 8'h57; cfg_wpol = 8'h54;
    rq(0, 0, 24); fl(24); rq(1, 0, 24); idle(2);
    // illegal policies (R11)
    cfg_wpol = 8'h45; rq(1, 0, 24); rq(0, 0, 24);
    cfg_wpol = 8'h52; rq(1, 0, 30); rq(0, 0, 30); fl(30);
    cfg_wpol = 8'h42; idle(3);
    // both ways in flight (R12)
    rq(0, 0, 19); rq(0, 0, 23); rq(0, 0, 27); idle(3); fl(19); fl(23); rq(0, 0, 27); fl(27);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom % 100);
      req_valid  = r < 70;
      req_write  = $urandom % 2 == 0;
      req_atomic = $urandom % 4 == 0;
      req_blk    = BLKW'($urandom % 32);
      fill_valid = $urandom % 4 == 0;
      fill_blk   = BLKW'($urandom % 32);
      mq_ready   = $urandom % 10 < 6;
      if (c % 500 == 0) begin
        r = int'($urandom % 6);
        cfg_wpol   = (r < 3) ? 8'h42 : (r == 3) ? 8'h54 : (r == 4) ? 8'h45 : 8'h52;
        cfg_walloc = ($urandom % 3 == 0) ? 8'h4E : 8'h57;
      end
      @(negedge clk);
    end
    req_valid = 0; fill_valid = 0; mq_ready = 1;
    idle(8);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule